// File: doc/BRIEF.md
# Stream Packet Insertion Multiplexer

This block sits inline on a packet stream in front of a device under test and picks, packet by packet, where the output traffic comes from. With the transparent source selected, beats from the upstream port pass combinationally to the downstream port, and ready flows back the same way. Nothing is added and no cycle is spent, so the block has no effect on the system. With the insert source selected, the upstream port is stalled. The output then carries packets that a host has written one 32-bit word at a time into an internal FIFO of 1024 entries.

Each host word becomes one stream beat. A flag written with the word marks the last beat of its packet. Buffered packets do not go out by themselves. Each start command from the host releases exactly one packet, so the host decides when injected traffic reaches the device. A change of source takes effect only between packets.

Top module: `pkt_insert_mux`

## Requirements
- R1: After reset the block is in transparent mode, `dnValid` is 0 while `upValid` is 0, `hostFull` is 0 and `upReady` equals `dnReady`.
- R2: In transparent mode, `dnData`, `dnLast` and `dnValid` equal `upData`, `upLast` and `upValid` in the same cycle, and `upReady` equals `dnReady`.
- R3: A change of `modeInsert` takes effect only at a packet boundary. In transparent mode this is after an accepted upstream beat with `upLast`=1. In insert mode this is after the released packet's last beat is accepted. Until then the previous source keeps driving the output.
- R4: While insert mode is in effect, `upReady` is 0. `dnValid` stays 0 until a start command is given.
- R5: A host word written with `hostWrEn`=1 appears later as one output beat with the same data. Its `dnLast` equals the `hostWrLast` flag it was written with, and words leave in write order.
- R6: A `startCmd` pulse given in insert mode releases exactly one packet: beats up to and including the next word flagged last. After that, `dnValid` returns to 0.
- R7: While a released beat is offered and `dnReady` is 0, `dnValid` stays 1 and `dnData`/`dnLast` stay unchanged.
- R8: `hostFull` is 1 exactly when 1024 words are buffered. A write while full is dropped and never reaches the output.
- R9: `startCmd` has no effect in transparent mode or while a packet is already being released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeInsert | input | 1 | Source request: 1 = inserted data, 0 = live upstream |
| startCmd | input | 1 | One-cycle command releasing one buffered packet |
| hostWrEn | input | 1 | Host word write strobe |
| hostWrData | input | 32 | Host word |
| hostWrLast | input | 1 | Marks the written word as the last of its packet |
| hostFull | output | 1 | FIFO holds 1024 words |
| upData | input | 32 | Upstream beat data |
| upLast | input | 1 | Upstream last beat |
| upValid | input | 1 | Upstream beat valid |
| upReady | output | 1 | Upstream ready |
| dnData | output | 32 | Downstream beat data |
| dnLast | output | 1 | Downstream last beat |
| dnValid | output | 1 | Downstream beat valid |
| dnReady | input | 1 | Downstream ready |

## Verification
Transparent-mode results are combinational, so they are sampled in the same cycle, a few nanoseconds after the inputs are driven. A source change, a start command and a host write each act at the next rising edge. The first released beat and any change of `hostFull` are therefore checked just after that edge. A mode request or start pulse is never judged in the cycle it is raised. Each released beat is compared in the cycle it is offered, before the edge that consumes it.

// File: rtl/pim_pkg.sv
package pim_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } srcState_t;

  typedef struct packed {
    logic passThru;
    logic drainEn;
  } ctrlStrobe_t;

  typedef struct packed {
    logic fifoEmpty;
    logic headLast;
  } dpStatus_t;

endpackage

// File: rtl/pim_ctrl.sv
module pim_ctrl
  import pim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeInsert,
  input  logic        startCmd,
  input  logic        upValid,
  input  logic        upReady,
  input  logic        upLast,
  input  logic        dnReady,
  input  dpStatus_t   dpStatus,
  output ctrlStrobe_t strobe
);

  srcState_t state, stateNext;
  logic      midPkt, midPktNext;
  logic      upFire, drainDone;

  assign upFire     = (state == ST_PASS) && upValid && upReady;
  assign midPktNext = upFire ? !upLast : midPkt;
  assign drainDone  = (state == ST_DRAIN) && !dpStatus.fifoEmpty &&
                      dnReady && dpStatus.headLast;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PASS:  if (modeInsert && !midPktNext) stateNext = ST_HOLD;
      ST_HOLD:  begin
        if (!modeInsert)   stateNext = ST_PASS;
        else if (startCmd) stateNext = ST_DRAIN;
      end
      ST_DRAIN: if (drainDone) stateNext = modeInsert ? ST_HOLD : ST_PASS;
      default:  stateNext = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_PASS;
      midPkt <= 1'b0;
    end else begin
      state  <= stateNext;
      midPkt <= midPktNext;
    end
  end

  assign strobe.passThru = (state == ST_PASS);
  assign strobe.drainEn  = (state == ST_DRAIN);

  // R3
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS && midPkt && !(upValid && upReady && upLast))
      |=> (state == ST_PASS));

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !(dnReady && !dpStatus.fifoEmpty && dpStatus.headLast))
      |=> (state == ST_DRAIN));

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS) |=> (state != ST_DRAIN));

endmodule

// File: rtl/pim_datapath.sv
module pim_datapath
  import pim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         dpStatus,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrLast,
  output logic              hostFull,
  input  logic [DATA_W-1:0] upData,
  input  logic              upLast,
  input  logic              upValid,
  output logic              upReady,
  output logic [DATA_W-1:0] dnData,
  output logic              dnLast,
  output logic              dnValid,
  input  logic              dnReady
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          empty, push, pop;
  logic [EW-1:0] head;

  assign empty    = (count == '0);
  assign hostFull = (count == FULL_CNT);
  assign push     = hostWrEn && !hostFull;
  assign pop      = strobe.drainEn && !empty && dnReady;
  assign head     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {hostWrLast, hostWrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dpStatus.fifoEmpty = empty;
  assign dpStatus.headLast  = head[DATA_W];

  always_comb begin
    if (strobe.passThru) begin
      dnData  = upData;
      dnLast  = upLast;
      dnValid = upValid;
      upReady = dnReady;
    end else begin
      dnData  = head[DATA_W-1:0];
      dnLast  = head[DATA_W];
      dnValid = strobe.drainEn && !empty;
      upReady = 1'b0;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostFull && hostWrEn && !pop) |=> (count == $past(count)));

  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drainEn && dnValid && !dnReady)
      |=> (dnValid && $stable(dnData) && $stable(dnLast)));

endmodule

// File: rtl/pkt_insert_mux.sv
module pkt_insert_mux
  import pim_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeInsert,
  input  logic              startCmd,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrLast,
  output logic              hostFull,
  input  logic [DATA_W-1:0] upData,
  input  logic              upLast,
  input  logic              upValid,
  output logic              upReady,
  output logic [DATA_W-1:0] dnData,
  output logic              dnLast,
  output logic              dnValid,
  input  logic              dnReady
);

  ctrlStrobe_t strobe;
  dpStatus_t   dpStatus;

  pim_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeInsert (modeInsert),
    .startCmd   (startCmd),
    .upValid    (upValid),
    .upReady    (upReady),
    .upLast     (upLast),
    .dnReady    (dnReady),
    .dpStatus   (dpStatus),
    .strobe     (strobe)
  );

  pim_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dpStatus   (dpStatus),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .hostWrLast (hostWrLast),
    .hostFull   (hostFull),
    .upData     (upData),
    .upLast     (upLast),
    .upValid    (upValid),
    .upReady    (upReady),
    .dnData     (dnData),
    .dnLast     (dnLast),
    .dnValid    (dnValid),
    .dnReady    (dnReady)
  );

endmodule

// File: tb/pkt_insert_mux_tb.sv
module pkt_insert_mux_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeInsert, startCmd, hostWrEn, hostWrLast, hostFull;
  logic [31:0] hostWrData, upData, dnData;
  logic        upLast, upValid, upReady, dnLast, dnValid, dnReady;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  pkt_insert_mux u_dut (
    .clk(clk), .rstN(rstN), .modeInsert(modeInsert), .startCmd(startCmd),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostWrLast(hostWrLast),
    .hostFull(hostFull), .upData(upData), .upLast(upLast), .upValid(upValid),
    .upReady(upReady), .dnData(dnData), .dnLast(dnLast), .dnValid(dnValid),
    .dnReady(dnReady)
  );

  // {data[35:4], last[3], valid[2], ready[1], expUpReady[0]}; dnValid expected = valid
  localparam logic [35:0] VECS [7] = '{
    {32'h0000_1001, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1002, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_1002, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h5A5A_A5A5, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic hostWrite(input logic [31:0] d, input logic l);
    hostWrEn = 1'b1; hostWrData = d; hostWrLast = l;
    nextCycle();
    hostWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    startCmd = 1'b1;
    nextCycle();
    startCmd = 1'b0;
  endtask

  task automatic expectBeat(input string req, input logic [31:0] d, input logic l);
    #4;
    chk(req, "dnValid", 64'(dnValid), 64'd1);
    chk(req, "dnData", 64'(dnData), 64'(d));
    chk(req, "dnLast", 64'(dnLast), 64'(l));
    chk("R4", "upReady", 64'(upReady), 64'd0);
    nextCycle();
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeInsert = 1'b0; startCmd = 1'b0; hostWrEn = 1'b0;
    hostWrData = '0; hostWrLast = 1'b0; upData = '0; upLast = 1'b0;
    upValid = 1'b0; dnReady = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #4;
    // R1 reset state
    chk("R1", "dnValid", 64'(dnValid), 64'd0);
    chk("R1", "hostFull", 64'(hostFull), 64'd0);
    chk("R1", "upReady", 64'(upReady), 64'd1);
    nextCycle();

    // R2 transparent table
    for (int i = 0; i < 7; i++) begin
      upData = VECS[i][35:4]; upLast = VECS[i][3];
      upValid = VECS[i][2]; dnReady = VECS[i][1];
      #4;
      chk("R2", "dnData", 64'(dnData), 64'(VECS[i][35:4]));
      chk("R2", "dnLast", 64'(dnLast), 64'(VECS[i][3]));
      chk("R2", "dnValid", 64'(dnValid), 64'(VECS[i][2]));
      chk("R2", "upReady", 64'(upReady), 64'(VECS[i][0]));
      nextCycle();
    end

    // R3 switch request mid-packet waits for last beat
    dnReady = 1'b1; upValid = 1'b1; upLast = 1'b0; upData = 32'h11;
    nextCycle();
    modeInsert = 1'b1; upData = 32'h22;
    #4;
    chk("R3", "upReady mid", 64'(upReady), 64'd1);
    chk("R3", "dnData mid", 64'(dnData), 64'h22);
    nextCycle();
    upData = 32'h33; upLast = 1'b1;
    #4;
    chk("R3", "dnValid last", 64'(dnValid), 64'd1);
    nextCycle();
    upData = 32'h44; upLast = 1'b1;
    #4;
    chk("R4", "upReady insert", 64'(upReady), 64'd0);
    chk("R4", "dnValid insert", 64'(dnValid), 64'd0);
    nextCycle();

    // R5 R6 load packets, nothing leaves before start
    hostWrite(32'hA0, 1'b0); hostWrite(32'hA1, 1'b0); hostWrite(32'hA2, 1'b1);
    hostWrite(32'hB0, 1'b0); hostWrite(32'hB1, 1'b1);
    hostWrite(32'hC0, 1'b1);
    #4;
    chk("R4", "dnValid before start", 64'(dnValid), 64'd0);
    chk("R4", "upReady before start", 64'(upReady), 64'd0);
    nextCycle();
    pulseStart();
    expectBeat("R5", 32'hA0, 1'b0);
    expectBeat("R5", 32'hA1, 1'b0);
    expectBeat("R5", 32'hA2, 1'b1);
    #4;
    chk("R6", "dnValid after packet", 64'(dnValid), 64'd0);
    nextCycle();

    // R7 stall, R9 start during drain
    dnReady = 1'b0;
    pulseStart();
    for (int k = 0; k < 3; k++) begin
      if (k == 1) startCmd = 1'b1;
      #4;
      chk("R7", "dnValid held", 64'(dnValid), 64'd1);
      chk("R7", "dnData held", 64'(dnData), 64'hB0);
      nextCycle();
      startCmd = 1'b0;
    end
    dnReady = 1'b1;
    expectBeat("R7", 32'hB0, 1'b0);
    expectBeat("R7", 32'hB1, 1'b1);
    #4;
    chk("R9", "start in drain ignored", 64'(dnValid), 64'd0);
    nextCycle();
    pulseStart();
    expectBeat("R6", 32'hC0, 1'b1);
    #4;
    chk("R6", "dnValid idle", 64'(dnValid), 64'd0);
    nextCycle();

    // R3 leaving insert mode waits for released packet end
    hostWrite(32'hD0, 1'b0); hostWrite(32'hD1, 1'b1);
    pulseStart();
    modeInsert = 1'b0;
    expectBeat("R3", 32'hD0, 1'b0);
    expectBeat("R3", 32'hD1, 1'b1);
    #4;
    chk("R3", "back to pass upReady", 64'(upReady), 64'd1);
    chk("R3", "back to pass dnData", 64'(dnData), 64'h44);
    nextCycle();
    upValid = 1'b0;

    // R9 start in transparent mode ignored
    hostWrite(32'hE0, 1'b1);
    pulseStart();
    modeInsert = 1'b1;
    nextCycle();
    #4;
    chk("R9", "start in pass ignored", 64'(dnValid), 64'd0);
    nextCycle();
    pulseStart();
    expectBeat("R9", 32'hE0, 1'b1);

    // R8 fill to capacity
    for (int w = 0; w < 1024; w++) begin
      if (w == 1023) begin
        #4;
        chk("R8", "hostFull at 1023", 64'(hostFull), 64'd0);
      end
      hostWrite(32'h1000_0000 + 32'(w), (w == 1023));
    end
    #4;
    chk("R8", "hostFull at 1024", 64'(hostFull), 64'd1);
    hostWrite(32'hDEAD_BEEF, 1'b1);
    #4;
    chk("R8", "hostFull after drop", 64'(hostFull), 64'd1);
    nextCycle();
    pulseStart();
    for (int w = 0; w < 1024; w++) begin
      expectBeat("R8", 32'h1000_0000 + 32'(w), (w == 1023));
    end
    #4;
    chk("R8", "hostFull drained", 64'(hostFull), 64'd0);
    nextCycle();
    pulseStart();
    #4;
    chk("R8", "dropped word absent", 64'(dnValid), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule